// File: doc/BRIEF.md
# Convolutional Interleaver with Per-Branch Delays

This block spreads a stream of symbols across a set of parallel delay lines (branches) so that neighbouring symbols leave the block far apart in time. A commutator sends each accepted symbol to the next branch in turn. The branch delays the symbol by the number of stages it holds, and the commutator then sends out whatever comes from the end of that branch. The number of branches and the depth of each one come from a parameter array, `BR_DELAY`. Its length is the branch count. Its entries may be in any order, and an entry of zero makes that branch a direct wire.

Every delay stage takes the value `INIT_VALUE` on reset. The first symbols out of each branch are therefore fill values until real data has made its way through. Storage is built per branch, so the block holds exactly the sum of the entries times `W` bits of state, plus one output register.

Both edges of the block use valid/ready handshakes. A symbol is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. An output is consumed where `out_valid` and `out_ready` are both high. The block has a one-entry output register: each accepted symbol yields exactly one output one cycle later. While an output waits, back-pressure reaches the input through `in_ready`, and the input is blocked only while that output is not being consumed.

Top module: `conv_interleaver_pb`

## Requirements
- R1: The branch count equals the length of `BR_DELAY`. Accepted symbol k, counted from reset, goes to branch k mod N, starting at branch 0.
- R2: A symbol accepted on visit v of branch i (visits counted from reset, starting at 0) is the output produced on visit v + `BR_DELAY[i]` of that branch.
- R3: A branch whose `BR_DELAY` entry is 0 returns the symbol accepted on the same visit, with no storage.
- R4: After reset the first `BR_DELAY[i]` outputs produced by branch i all equal `INIT_VALUE`.
- R5: A branch's stages move only on a cycle where a symbol is accepted and the commutator points at that branch. Idle cycles and visits to other branches leave its contents unchanged.
- R6: Each accepted symbol produces exactly one output. It appears with `out_valid` high on the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R7: `in_ready` is high exactly when the output register is empty or is being consumed in the same cycle (`!out_valid || out_ready`).
- R8: Synchronous reset, even in the middle of a stream, refills every stage with `INIT_VALUE`, returns the commutator to branch 0 and clears `out_valid`.
- R9: When no symbol is accepted and the pending output is consumed, `out_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers `in_data` |
| in_ready | output | 1 | Block can accept a symbol this cycle |
| in_data | input | W | Input symbol |
| out_valid | output | 1 | `out_data` holds an interleaved symbol |
| out_ready | input | 1 | Downstream takes `out_data` this cycle |
| out_data | output | W | Interleaved output symbol |

## Verification
The hardest condition to reach is a branch that keeps its contents through a long run of cycles in which other branches are visited, the input is idle, or the output is stalled. Only those cycles can expose a line that shifts on the wrong enable. The stimulus combines back-to-back bursts with random gaps on `in_valid` and random stalls on `out_ready`. The branch count (5) and the deepest branch (9) are chosen so that every line sits untouched for many cycles before its stored symbols come out. A reset in the middle of a stream then checks that fill values appear again and that the branch order starts over from branch 0.

// File: rtl/ci_pkg.sv
package ci_pkg;
  // Width of an index that addresses n items (at least one bit).
  function automatic int unsigned ci_idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ci_commutator.sv
module ci_commutator #(
  parameter int unsigned N_BR  = 4,
  parameter int unsigned PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_BR - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R1: the commutator moves only when a symbol is accepted
  a_r1_ptr_idle : assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));

  // R1: the pointer never leaves the branch range
  a_r1_ptr_bound : assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
endmodule

// File: rtl/ci_branch.sv
module ci_branch #(
  parameter int unsigned W          = 8,
  parameter int unsigned DEPTH      = 3,
  parameter logic [W-1:0] INIT_VALUE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      // R3: zero-delay branch is a direct path
      assign dout = din;
    end else begin : g_line
      logic [W-1:0] stg [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < DEPTH; j++) stg[j] <= INIT_VALUE;
        end else if (shift_en) begin
          stg[0] <= din;
          for (int j = 1; j < DEPTH; j++) stg[j] <= stg[j-1];
        end
      end

      assign dout = stg[DEPTH-1];

      // R5: a branch that is not selected keeps its oldest entry
      a_r5_hold_unselected : assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(dout));
    end
  endgenerate
endmodule

// File: rtl/ci_out_stage.sv
module ci_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         free,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: a stalled output is held unchanged
  a_r6_hold_stall : assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: an accepted symbol shows up on the next cycle
  a_r6_one_out : assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R9: consumed with nothing new behind it leaves the register empty
  a_r9_drain : assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !take |=> !out_valid);
endmodule

// File: rtl/conv_interleaver_pb.sv
module conv_interleaver_pb
  import ci_pkg::*;
#(
  parameter int unsigned  W                  = 8,
  parameter int unsigned  N_BR               = 4,
  parameter int unsigned  BR_DELAY [N_BR]    = '{3, 6, 9, 2},
  parameter logic [W-1:0] INIT_VALUE         = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned PTR_W = ci_idx_w(N_BR);

  logic             accept;
  logic [PTR_W-1:0] ptr;
  logic [W-1:0]     br_out [N_BR];
  logic [W-1:0]     sel_out;

  assign accept = in_valid && in_ready;

  ci_commutator #(
    .N_BR  (N_BR),
    .PTR_W (PTR_W)
  ) u_comm (
    .clk (clk),
    .rst (rst),
    .adv (accept),
    .ptr (ptr)
  );

  generate
    for (genvar b = 0; b < N_BR; b++) begin : g_br
      ci_branch #(
        .W          (W),
        .DEPTH      (BR_DELAY[b]),
        .INIT_VALUE (INIT_VALUE)
      ) u_branch (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept && (ptr == PTR_W'(b))),
        .din      (in_data),
        .dout     (br_out[b])
      );
    end
  endgenerate

  always_comb begin
    sel_out = '0;
    for (int b = 0; b < N_BR; b++) begin
      if (ptr == PTR_W'(b)) sel_out = br_out[b];
    end
  end

  ci_out_stage #(
    .W (W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .take      (accept),
    .din       (sel_out),
    .out_ready (out_ready),
    .free      (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: tb/conv_interleaver_pb_tb.sv
module conv_interleaver_pb_tb;
  localparam int unsigned  W    = 8;
  localparam int unsigned  NB   = 5;
  localparam int unsigned  DLY [NB] = '{3, 6, 0, 9, 2};
  localparam logic [W-1:0] INIT = 8'hA5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int rdy_mode = 0;

  // Reference model state
  logic [W-1:0] br_q [NB][$];
  int           init_left [NB];
  int           ptr_m = 0;
  logic [W-1:0] exp_d [$];
  string        exp_t [$];
  string        init_tag = "R4";

  always #5 clk = ~clk;

  conv_interleaver_pb #(
    .W          (W),
    .N_BR       (NB),
    .BR_DELAY   (DLY),
    .INIT_VALUE (INIT)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      br_q[b].delete();
      for (int j = 0; j < int'(DLY[b]); j++) br_q[b].push_back(INIT);
      init_left[b] = DLY[b];
    end
    ptr_m = 0;
    exp_d.delete();
    exp_t.delete();
  endtask

  // Driver: called at a falling edge; returns at a falling edge.
  task automatic send(input logic [W-1:0] d);
    logic [W-1:0] item;
    string tag;
    in_valid = 1'b1;
    in_data  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    // accepted at the next rising edge: R1 cyclic branch choice
    br_q[ptr_m].push_back(d);
    item = br_q[ptr_m].pop_front();
    if (DLY[ptr_m] == 0) tag = "R3";
    else if (init_left[ptr_m] > 0) begin
      tag = init_tag;
      init_left[ptr_m]--;
    end else tag = "R1/R2";
    exp_d.push_back(item);
    exp_t.push_back(tag);
    ptr_m = (ptr_m + 1) % NB;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Downstream readiness
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  // Monitor / scoreboard
  initial begin
    bit         prev_stall = 1'b0;
    logic [W-1:0] prev_data = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        prev_stall = 1'b0;
      end else begin
        // R7: ready rule
        check(in_ready == (!out_valid || out_ready), "R7", W'(in_ready),
              W'(!out_valid || out_ready));
        if (prev_stall) begin
          // R6: held while stalled
          check(out_valid && out_data == prev_data, "R6", out_data, prev_data);
        end
        if (out_valid && out_ready) begin
          if (exp_d.size() == 0) begin
            check(1'b0, "R6/R9", out_data, '0);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_d.pop_front();
            t = exp_t.pop_front();
            check(out_data == e, t, out_data, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8: reset state
    check(out_valid == 1'b0, "R8", W'(out_valid), 8'h0);
    check(in_ready == 1'b1, "R7", W'(in_ready), 8'h1);
    @(negedge clk);

    // Back-to-back stream, always ready (R1, R2, R3, R4)
    rdy_mode = 0;
    for (int k = 0; k < 60; k++) send(W'(k + 1));
    idle(3);

    // Gaps and stalls: R5 stages hold through idle cycles, R9 drain
    rdy_mode = 1;
    for (int k = 0; k < 150; k++) begin
      send(W'(8'h40 + k));
      if (($urandom % 4) == 0) idle(1 + ($urandom % 6));
    end

    // Mid-stream reset: R8 refill and pointer back to branch 0
    rst = 1'b1;
    repeat (2) @(negedge clk);
    model_reset();
    init_tag = "R8";
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R8", W'(out_valid), 8'h0);
    @(negedge clk);
    for (int k = 0; k < 80; k++) begin
      send(W'(8'hC0 + k));
      if (($urandom % 5) == 0) idle(1 + ($urandom % 4));
    end

    // Drain
    rdy_mode = 0;
    idle(10);
    check(exp_d.size() == 0, "R6", W'(exp_d.size()), 8'h0);
    check(out_valid == 1'b0, "R9", W'(out_valid), 8'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule